// File: doc/BRIEF.md
# Power Domain Hardware Voter

The voter turns power-on and power-off votes from software into handshakes with a set of power switches, one switch per domain. Software votes through two write-one-to-act strobes, one for turning domains on and one for turning them off. Each bit position stands for one domain, and the same position is used in every readback register. A sequencer for each domain accepts a vote only while that domain is idle. It then drives the domain's switch request and waits for the switch to report the new state. Status readback tells software three things: whether the voter can take a command, whether a command has been picked up, and whether the domain has settled.

A domain counts as on only when its primary status word and its secondary status word both show a set bit under their masks. The secondary mask falls back to the primary mask when it is zero. Turning a domain off includes a settle window of a configurable number of cycles. The window starts when the switch request drops, and it must pass before completion is reported.

Top module: `pdv_voter`

## Requirements
- R1: After a synchronous active-low reset, every domain reads DONE=1, EN=0, SET_STA=0, CLR_STA=0 and set-readback=1, clr-readback reads 0, and `pwr_req` is 0.
- R2: A domain's DONE bit is 1 only while its sequencer is idle. It is 0 from the cycle after a command is accepted until the cycle after that command completes.
- R3: In the cycle after an accepted power-on vote, that domain's set-readback bit reads 0. From the following cycle on, it reads 1 again.
- R4: In the cycle after an accepted power-off vote, that domain's clr-readback bit reads 1. From the following cycle on, it reads 0.
- R5: An accepted power-on vote sets SET_STA at once and raises `pwr_req` one cycle later. Once the domain decodes as on, the next cycle shows DONE=1, EN=1 and SET_STA=0.
- R6: An accepted power-off vote sets CLR_STA at once and drops `pwr_req` one cycle later. CLR_STA stays 1 for the SETTLE_CYC cycles that follow. It clears, together with DONE=1 and EN=0, one cycle after the window ends and the domain decodes as off. With an already-off switch, this happens SETTLE_CYC+2 cycles after the accepting edge.
- R7: A domain decodes as on when both of these hold: its primary status ANDed with PRI_MASK is nonzero, and its secondary status ANDed with the effective secondary mask is nonzero. The effective secondary mask is SEC_MASK, or PRI_MASK when SEC_MASK is zero. Domain i uses status and mask bits [i*STA_W +: STA_W].
- R8: A vote written to a domain whose DONE is 0 is ignored.
- R9: When the on-strobe and the off-strobe both carry a 1 for the same domain in the same cycle, both votes for that domain are ignored. Other domains in the same write act on their own bits.
- R10: Read address 0 returns set-readback, 1 clr-readback, 2 DONE, 3 EN, 4 SET_STA and 5 CLR_STA, with bit i for domain i. Addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| set_wr_en | input | 1 | Power-on vote strobe |
| set_wr_data | input | N_DOM | Domains voted on |
| clr_wr_en | input | 1 | Power-off vote strobe |
| clr_wr_data | input | N_DOM | Domains voted off |
| rd_addr | input | 3 | Readback register select |
| rd_data | output | N_DOM | Combinational readback |
| sta_pri | input | N_DOM*STA_W | Primary power status from the switches |
| sta_sec | input | N_DOM*STA_W | Secondary power status from the switches |
| pwr_req | output | N_DOM | Power switch request, one per domain |

## Verification
The bench builds the voter with four domains, two status bits each and a settle window of six cycles. This makes the full off sequence, including the exact count from vote to completion, short enough to check on every clock. Domain 1 gets its own secondary mask (bit 1) while the other domains fall back to the primary mask (bit 0). A status value on the wrong secondary bit can then be shown to block completion. The switch models use per-domain acknowledge delays. One of them is longer than the settle window, so an off vote is seen ending both at the window edge and later, on the acknowledge.

// File: rtl/pdv_pkg.sv
// Shared definitions for the power domain voter: readback map and
// sequencer state encoding. Assumes a 3-bit readback address.
package pdv_pkg;
    localparam int RD_ADDR_W = 3;

    localparam logic [RD_ADDR_W-1:0] RA_SET_RB  = 3'd0;
    localparam logic [RD_ADDR_W-1:0] RA_CLR_RB  = 3'd1;
    localparam logic [RD_ADDR_W-1:0] RA_DONE    = 3'd2;
    localparam logic [RD_ADDR_W-1:0] RA_EN      = 3'd3;
    localparam logic [RD_ADDR_W-1:0] RA_SET_STA = 3'd4;
    localparam logic [RD_ADDR_W-1:0] RA_CLR_STA = 3'd5;

    typedef enum logic [2:0] {
        PD_IDLE,
        PD_ON_PREP,
        PD_ON_WAIT,
        PD_OFF_PREP,
        PD_OFF_SETTLE,
        PD_OFF_WAIT
    } pd_state_t;
endpackage

// File: rtl/pdv_on_detect.sv
// Decodes one domain's primary and secondary status words into a single
// "on" flag. Assumes masks are constant; a zero secondary mask means the
// primary mask is reused for the secondary word.
module pdv_on_detect #(
    parameter int                 STA_W    = 2,
    parameter logic [STA_W-1:0]   PRI_MASK = '1,
    parameter logic [STA_W-1:0]   SEC_MASK = '0
) (
    input  logic [STA_W-1:0] sta_pri,
    input  logic [STA_W-1:0] sta_sec,
    output logic             is_on
);
    localparam logic [STA_W-1:0] SEC_EFF = (SEC_MASK != '0) ? SEC_MASK : PRI_MASK;

    // on only when both masked status words show a set bit
    always_comb begin
        is_on = (|(sta_pri & PRI_MASK)) && (|(sta_sec & SEC_EFF));
    end
endmodule

// File: rtl/pdv_domain_seq.sv
// Per-domain command sequencer. Takes an accepted on or off command, walks
// the prepare, request and acknowledge phases (with a settle window on the
// off path) and reports idle, pending and enabled state. Assumes the
// command inputs are only asserted while the domain is idle and never both.
module pdv_domain_seq
    import pdv_pkg::*;
#(
    parameter int SETTLE_CYC = 25000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_cmd,
    input  logic clr_cmd,
    input  logic is_on,
    output logic req_o,
    output logic done_o,
    output logic en_o,
    output logic set_sta_o,
    output logic clr_sta_o,
    output logic set_rb_o,
    output logic clr_rb_o
);
    localparam int               CNT_W = $clog2(SETTLE_CYC + 1);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] FULL  = CNT_W'(SETTLE_CYC);

    pd_state_t        state;
    logic [CNT_W-1:0] cnt;

    // sequencer state, switch request, enabled flag and settle counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PD_IDLE;
            req_o <= 1'b0;
            en_o  <= 1'b0;
            cnt   <= '0;
        end else begin
            case (state)
                PD_IDLE: begin
                    if (set_cmd)      state <= PD_ON_PREP;
                    else if (clr_cmd) state <= PD_OFF_PREP;
                end
                PD_ON_PREP: begin
                    state <= PD_ON_WAIT;
                    req_o <= 1'b1;
                end
                PD_ON_WAIT: begin
                    if (is_on) begin
                        state <= PD_IDLE;
                        en_o  <= 1'b1;
                    end
                end
                PD_OFF_PREP: begin
                    state <= PD_OFF_SETTLE;
                    req_o <= 1'b0;
                    cnt   <= '0;
                end
                PD_OFF_SETTLE: begin
                    if (cnt == LAST) state <= PD_OFF_WAIT;
                    else             cnt   <= cnt + 1'b1;
                end
                PD_OFF_WAIT: begin
                    if (!is_on) begin
                        state <= PD_IDLE;
                        en_o  <= 1'b0;
                    end
                end
                default: state <= PD_IDLE;
            endcase
        end
    end

    // status and readback decode from the state
    always_comb begin
        done_o    = (state == PD_IDLE);
        set_sta_o = (state == PD_ON_PREP) || (state == PD_ON_WAIT);
        clr_sta_o = (state == PD_OFF_PREP) || (state == PD_OFF_SETTLE) || (state == PD_OFF_WAIT);
        set_rb_o  = (state != PD_ON_PREP);
        clr_rb_o  = (state == PD_OFF_PREP);
    end

    // assertion-side counter of cycles with the request low, saturating
    logic [CNT_W-1:0] low_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)              low_cnt <= FULL;
        else if (req_o)          low_cnt <= '0;
        else if (low_cnt != FULL) low_cnt <= low_cnt + 1'b1;
    end

    a_r8_cmd_only_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (set_cmd || clr_cmd) |-> done_o);
    a_r9_single_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_cmd && clr_cmd));
    a_r5_en_rises_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_o) |-> $past(is_on));
    a_r6_en_falls_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en_o) |-> !$past(is_on));
    a_r5_req_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_o) |-> $past(set_sta_o));
    a_r6_settle_window: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clr_sta_o) |-> (low_cnt >= FULL));
endmodule

// File: rtl/pdv_regif.sv
// Vote decode and status readback. Filters votes so that only idle
// domains with a single, unambiguous vote receive a command, and muxes the
// status vectors onto the read port. Assumes reads are combinational.
module pdv_regif
    import pdv_pkg::*;
#(
    parameter int N_DOM = 4
) (
    input  logic                 set_wr_en,
    input  logic [N_DOM-1:0]     set_wr_data,
    input  logic                 clr_wr_en,
    input  logic [N_DOM-1:0]     clr_wr_data,
    input  logic [N_DOM-1:0]     done_vec,
    input  logic [N_DOM-1:0]     en_vec,
    input  logic [N_DOM-1:0]     set_sta_vec,
    input  logic [N_DOM-1:0]     clr_sta_vec,
    input  logic [N_DOM-1:0]     set_rb_vec,
    input  logic [N_DOM-1:0]     clr_rb_vec,
    input  logic [RD_ADDR_W-1:0] rd_addr,
    output logic [N_DOM-1:0]     set_cmd,
    output logic [N_DOM-1:0]     clr_cmd,
    output logic [N_DOM-1:0]     rd_data
);
    logic [N_DOM-1:0] set_req;
    logic [N_DOM-1:0] clr_req;
    logic [N_DOM-1:0] clash;

    // gate votes: idle domains only, conflicting votes dropped
    always_comb begin
        set_req = set_wr_en ? set_wr_data : '0;
        clr_req = clr_wr_en ? clr_wr_data : '0;
        clash   = set_req & clr_req;
        set_cmd = set_req & ~clash & done_vec;
        clr_cmd = clr_req & ~clash & done_vec;
    end

    // readback register select
    always_comb begin
        case (rd_addr)
            RA_SET_RB:  rd_data = set_rb_vec;
            RA_CLR_RB:  rd_data = clr_rb_vec;
            RA_DONE:    rd_data = done_vec;
            RA_EN:      rd_data = en_vec;
            RA_SET_STA: rd_data = set_sta_vec;
            RA_CLR_STA: rd_data = clr_sta_vec;
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/pdv_voter.sv
// Top of the power domain voter: one status decoder and one sequencer per
// domain, plus the shared vote filter and readback. Assumes status inputs
// are synchronous to clk and SETTLE_CYC is at least 1.
module pdv_voter
    import pdv_pkg::*;
#(
    parameter int                         N_DOM      = 4,
    parameter int                         STA_W      = 2,
    parameter int                         SETTLE_CYC = 25000,
    parameter logic [N_DOM*STA_W-1:0]     PRI_MASK   = '1,
    parameter logic [N_DOM*STA_W-1:0]     SEC_MASK   = '0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   set_wr_en,
    input  logic [N_DOM-1:0]       set_wr_data,
    input  logic                   clr_wr_en,
    input  logic [N_DOM-1:0]       clr_wr_data,
    input  logic [RD_ADDR_W-1:0]   rd_addr,
    output logic [N_DOM-1:0]       rd_data,
    input  logic [N_DOM*STA_W-1:0] sta_pri,
    input  logic [N_DOM*STA_W-1:0] sta_sec,
    output logic [N_DOM-1:0]       pwr_req
);
    logic [N_DOM-1:0] set_cmd, clr_cmd, on_vec;
    logic [N_DOM-1:0] done_vec, en_vec, set_sta_vec, clr_sta_vec, set_rb_vec, clr_rb_vec;

    pdv_regif #(.N_DOM(N_DOM)) u_regif (
        .set_wr_en   (set_wr_en),
        .set_wr_data (set_wr_data),
        .clr_wr_en   (clr_wr_en),
        .clr_wr_data (clr_wr_data),
        .done_vec    (done_vec),
        .en_vec      (en_vec),
        .set_sta_vec (set_sta_vec),
        .clr_sta_vec (clr_sta_vec),
        .set_rb_vec  (set_rb_vec),
        .clr_rb_vec  (clr_rb_vec),
        .rd_addr     (rd_addr),
        .set_cmd     (set_cmd),
        .clr_cmd     (clr_cmd),
        .rd_data     (rd_data)
    );

    for (genvar i = 0; i < N_DOM; i++) begin : g_dom
        pdv_on_detect #(
            .STA_W    (STA_W),
            .PRI_MASK (PRI_MASK[i*STA_W +: STA_W]),
            .SEC_MASK (SEC_MASK[i*STA_W +: STA_W])
        ) u_det (
            .sta_pri (sta_pri[i*STA_W +: STA_W]),
            .sta_sec (sta_sec[i*STA_W +: STA_W]),
            .is_on   (on_vec[i])
        );

        pdv_domain_seq #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_cmd   (set_cmd[i]),
            .clr_cmd   (clr_cmd[i]),
            .is_on     (on_vec[i]),
            .req_o     (pwr_req[i]),
            .done_o    (done_vec[i]),
            .en_o      (en_vec[i]),
            .set_sta_o (set_sta_vec[i]),
            .clr_sta_o (clr_sta_vec[i]),
            .set_rb_o  (set_rb_vec[i]),
            .clr_rb_o  (clr_rb_vec[i])
        );
    end
endmodule

// File: tb/tb_pdv_voter.sv
`timescale 1ns/100ps
module tb_pdv_voter;
    localparam int N = 4;
    localparam int W = 2;
    localparam int S = 6;
    localparam logic [N*W-1:0] PM = 8'b01_01_01_01;
    localparam logic [N*W-1:0] SM = 8'b00_00_10_00;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           set_wr_en = 1'b0, clr_wr_en = 1'b0;
    logic [N-1:0]   set_wr_data = '0, clr_wr_data = '0;
    logic [2:0]     rd_addr = '0;
    logic [N-1:0]   rd_data;
    logic [N*W-1:0] sta_pri = '0, sta_sec = '0;
    logic [N-1:0]   pwr_req;

    pdv_voter #(.N_DOM(N), .STA_W(W), .SETTLE_CYC(S), .PRI_MASK(PM), .SEC_MASK(SM)) dut (
        .clk(clk), .rst_n(rst_n),
        .set_wr_en(set_wr_en), .set_wr_data(set_wr_data),
        .clr_wr_en(clr_wr_en), .clr_wr_data(clr_wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .sta_pri(sta_pri), .sta_sec(sta_sec), .pwr_req(pwr_req)
    );

    always #2 clk = ~clk;

    int tests = 0;
    int fails = 0;

    // reference model: phase 0 idle, 1 on-accepted, 2 on-waiting,
    // 3 off-accepted, 4 settling, 5 off-waiting
    int ph[N];
    int cnt[N];
    bit mreq[N];
    bit men[N];

    // switch environment
    int   edly[N] = '{2, 1, 10, 3};
    bit   est[N];
    int   ecnt[N];
    bit   ovr[N];
    logic [W-1:0] opri[N];
    logic [W-1:0] osec[N];

    task automatic chk(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic bit dom_on(int i);
        logic [W-1:0] p, s, pm, sm;
        p  = sta_pri[i*W +: W];
        s  = sta_sec[i*W +: W];
        pm = PM[i*W +: W];
        sm = (SM[i*W +: W] != 0) ? SM[i*W +: W] : pm;
        return ((p & pm) != 0) && ((s & sm) != 0);
    endfunction

    task automatic model_next();
        for (int i = 0; i < N; i++) begin
            if (!rst_n) begin
                ph[i] = 0; cnt[i] = 0; mreq[i] = 0; men[i] = 0;
            end else begin
                bit sv, cv;
                sv = set_wr_en && set_wr_data[i];
                cv = clr_wr_en && clr_wr_data[i];
                if (sv && cv) begin sv = 0; cv = 0; end
                case (ph[i])
                    0: if (sv) ph[i] = 1; else if (cv) ph[i] = 3;
                    1: begin ph[i] = 2; mreq[i] = 1; end
                    2: if (dom_on(i)) begin ph[i] = 0; men[i] = 1; end
                    3: begin ph[i] = 4; mreq[i] = 0; cnt[i] = 0; end
                    4: if (cnt[i] == S - 1) ph[i] = 5; else cnt[i]++;
                    5: if (!dom_on(i)) begin ph[i] = 0; men[i] = 0; end
                    default: ph[i] = 0;
                endcase
            end
        end
    endtask

    function automatic logic [N-1:0] exp_rd(int a);
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) begin
            case (a)
                0: v[i] = (ph[i] != 1);
                1: v[i] = (ph[i] == 3);
                2: v[i] = (ph[i] == 0);
                3: v[i] = men[i];
                4: v[i] = (ph[i] == 1) || (ph[i] == 2);
                5: v[i] = (ph[i] >= 3);
                default: v[i] = 1'b0;
            endcase
        end
        return v;
    endfunction

    task automatic rd(input logic [2:0] a, output logic [N-1:0] v);
        rd_addr = a;
        #0.1;
        v = rd_data;
    endtask

    task automatic compare_all();
        string tags[8] = '{"R3 set-rb", "R4 clr-rb", "R2 done", "R5 en",
                           "R5 set-sta", "R6 clr-sta", "R10 unmapped", "R10 unmapped"};
        logic [N-1:0] v, r;
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            chk(tags[a], v, exp_rd(a));
        end
        for (int i = 0; i < N; i++) r[i] = mreq[i];
        chk("R5 pwr_req", pwr_req, r);
    endtask

    task automatic env_update();
        for (int i = 0; i < N; i++) begin
            if (pwr_req[i] != est[i]) begin
                ecnt[i]++;
                if (ecnt[i] >= edly[i]) begin est[i] = pwr_req[i]; ecnt[i] = 0; end
            end else ecnt[i] = 0;
            sta_pri[i*W +: W] = ovr[i] ? opri[i] : {W{est[i]}};
            sta_sec[i*W +: W] = ovr[i] ? osec[i] : {W{est[i]}};
        end
    endtask

    task automatic step();
        model_next();
        @(posedge clk);
        @(negedge clk);
        set_wr_en = 1'b0; clr_wr_en = 1'b0;
        set_wr_data = '0; clr_wr_data = '0;
        compare_all();
        env_update();
    endtask

    task automatic vote(input logic [N-1:0] on_bits, input logic [N-1:0] off_bits);
        set_wr_en = (on_bits != 0);  set_wr_data = on_bits;
        clr_wr_en = (off_bits != 0); clr_wr_data = off_bits;
        step();
    endtask

    task automatic run_until_done(input int i, input int maxc);
        logic [N-1:0] v;
        for (int k = 0; k < maxc; k++) begin
            rd(3'd2, v);
            if (v[i]) break;
            step();
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [N-1:0] v;
        int n;
        for (int i = 0; i < N; i++) begin
            est[i] = 0; ecnt[i] = 0; ovr[i] = 0; opri[i] = '0; osec[i] = '0;
        end
        @(negedge clk);
        repeat (3) step();
        rst_n = 1'b1;

        // R1 reset state
        rd(3'd2, v); chk("R1 done after reset", v, 4'hF);
        rd(3'd3, v); chk("R1 en after reset", v, 4'h0);
        rd(3'd0, v); chk("R1 set-rb after reset", v, 4'hF);
        rd(3'd1, v); chk("R1 clr-rb after reset", v, 4'h0);
        chk("R1 pwr_req after reset", pwr_req, 4'h0);
        step();

        // R3 R5: power on domain 0
        vote(4'b0001, 4'b0000);
        rd(3'd0, v); chk("R3 set-rb low after accept", v & 4'b0001, 4'b0000);
        rd(3'd2, v); chk("R2 done low after accept", v & 4'b0001, 4'b0000);
        rd(3'd4, v); chk("R5 set-sta after accept", v & 4'b0001, 4'b0001);
        step();
        rd(3'd0, v); chk("R3 set-rb back high", v & 4'b0001, 4'b0001);
        chk("R5 request raised", pwr_req & 4'b0001, 4'b0001);
        run_until_done(0, 40);
        rd(3'd3, v); chk("R5 en after power on", v & 4'b0001, 4'b0001);
        rd(3'd4, v); chk("R5 set-sta cleared", v & 4'b0001, 4'b0000);

        // R8: off vote to a busy domain is ignored
        vote(4'b0100, 4'b0000);
        vote(4'b0000, 4'b0100);
        rd(3'd5, v); chk("R8 clr-sta after busy vote", v & 4'b0100, 4'b0000);
        run_until_done(2, 60);
        rd(3'd3, v); chk("R8 domain 2 stays on", v & 4'b0100, 4'b0100);
        step();
        rd(3'd5, v); chk("R8 no late off", v & 4'b0100, 4'b0000);

        // R9: conflicting votes for domain 1, clean vote for domain 3
        vote(4'b1010, 4'b0010);
        rd(3'd2, v); chk("R9 domain 1 still idle", v & 4'b0010, 4'b0010);
        rd(3'd4, v); chk("R9 set-sta only domain 3", v & 4'b1010, 4'b1000);
        rd(3'd5, v); chk("R9 no clr-sta domain 1", v & 4'b0010, 4'b0000);
        run_until_done(3, 40);

        // R7: domain 1 own secondary mask (bit 1)
        ovr[1] = 1; opri[1] = 2'b01; osec[1] = 2'b01;
        env_update();
        vote(4'b0010, 4'b0000);
        repeat (20) step();
        rd(3'd2, v); chk("R7 wrong secondary bit blocks on", v & 4'b0010, 4'b0000);
        osec[1] = 2'b10;
        env_update();
        step(); step();
        rd(3'd2, v); chk("R7 own secondary bit completes", v & 4'b0010, 4'b0010);
        rd(3'd3, v); chk("R7 en domain 1", v & 4'b0010, 4'b0010);
        ovr[1] = 0;

        // R4 R6: power off domain 0, fast ack
        vote(4'b0000, 4'b0001);
        rd(3'd1, v); chk("R4 clr-rb high after accept", v & 4'b0001, 4'b0001);
        rd(3'd5, v); chk("R6 clr-sta after accept", v & 4'b0001, 4'b0001);
        n = 0;
        step(); n++;
        rd(3'd1, v); chk("R4 clr-rb low", v & 4'b0001, 4'b0000);
        chk("R6 request dropped", pwr_req & 4'b0001, 4'b0000);
        for (int k = 0; k < 40; k++) begin
            rd(3'd5, v);
            if (!v[0]) break;
            step(); n++;
        end
        chk("R6 off latency cycles", 4'(n), 4'(S + 2));
        rd(3'd3, v); chk("R6 en low after off", v & 4'b0001, 4'b0000);
        rd(3'd2, v); chk("R6 done after off", v & 4'b0001, 4'b0001);

        // R6: domain 2 slow ack, past the settle window
        vote(4'b0000, 4'b0100);
        run_until_done(2, 60);
        rd(3'd3, v); chk("R6 slow off en low", v & 4'b0100, 4'b0000);

        // R5: re-vote on for a domain already on (domain 3)
        vote(4'b1000, 4'b0000);
        run_until_done(3, 20);
        rd(3'd3, v); chk("R5 re-on keeps en", v & 4'b1000, 4'b1000);

        // R10: unmapped reads
        rd(3'd6, v); chk("R10 address 6", v, 4'h0);
        rd(3'd7, v); chk("R10 address 7", v, 4'h0);
        repeat (4) step();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule